// File: doc/BRIEF.md
# Debug System Bus Access Controller

This block lets an external debugger reach system memory without the processor's help. The debugger sees five word registers on a narrow register port: a control/status word, a 64-bit address split into low and high halves, and a data word with an upper companion. Register reads and writes are single-cycle strobes. Read data comes back combinationally in the same cycle, and any side effect takes hold at the clock edge that ends the cycle.

Behind the registers sits a single-outstanding access engine that drives a request/ready memory bus. A read can start in three ways: a write to the low address while read-on-address is enabled, a read of the low data word while read-on-data is enabled, or, for a write access, a write to the low data word. With auto-increment enabled, the address steps by the access size after every successful transfer, so a debugger can stream a block of memory by reading the data word over and over. A sticky busy-error flag reports accesses that collided with one still in flight, and a 3-bit error code reports a refused size or a failed bus response. While either one is set, no further bus traffic is started.

Top module: `sba_ctrl`

## Requirements
- R1: After reset the control word at offset 0x38 reads 0x20000807: version 1 in bits 31:29, address width 64 in bits 11:5, size-support flags 3'b111 in bits 2:0, and every other bit zero. The address registers (0x39 low, 0x3a high) and the data registers (0x3c low, 0x3d high) read zero.
- R2: The control fields are read-on-data in bit 15, auto-increment in bit 16, access size in bits 19:17 (0 = 8, 1 = 16, 2 = 32 bits) and read-on-address in bit 20. They read back as written. Bit 21 (busy) is read-only, and a control write starts no access.
- R3: A write to 0x39 with read-on-address set starts a bus read at the written address. Busy (bit 21) and mem_req are high from the cycle after the write until the edge where the response is captured into the data register.
- R4: A read of 0x3c while idle, with read-on-data set and the error code zero, returns the held data and starts a bus read at the current address.
- R5: After each successful access with auto-increment set, the address advances by 1, 2 or 4 for sizes 0, 1 and 2. With auto-increment clear, the address is left unchanged.
- R6: A write to 0x3c while idle and error-free stores the word and starts a bus write of it to the current address.
- R7: While an access is in flight, a read of 0x3c returns the current data and sets busy-error (bit 22) without starting an access. A write to 0x39, 0x3a or 0x3c in that window also sets busy-error and is dropped.
- R8: Busy-error is sticky. Writing 1 to bit 22 clears it, and writing 0 there leaves it set.
- R9: A bus error response sets the error code (bits 14:12) to 7 and leaves the address and data unchanged. Each bit of the code is cleared by writing 1 to it.
- R10: While busy-error is set or the error code is nonzero, no bus access starts. Address and data writes still update their registers.
- R11: An access attempt with a size value above 2 sets the error code to 4 and starts no access.
- R12: Reads of 8 or 16 bits put the addressed bytes, zero-extended, into the data word. mem_size carries the access size.
- R13: The high address at 0x3a reads back as written and drives mem_addr[63:32]. The word at 0x3d always reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Register access strobe, one cycle per access |
| dbg_we | input | 1 | 1 = register write, 0 = register read |
| dbg_addr | input | 7 | Register offset |
| dbg_wdata | input | 32 | Register write data |
| dbg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| mem_req | output | 1 | Bus request, held until mem_ready |
| mem_we | output | 1 | 1 = bus write |
| mem_addr | output | ADDR_W | Bus byte address |
| mem_size | output | 3 | Access size code |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus response valid; ends the access |
| mem_err | input | 1 | Bus error, valid with mem_ready |
| mem_rdata | input | 32 | Bus read data, valid with mem_ready |

## Verification
The in-RTL assertions check on every cycle that busy rises after each launch and falls on the response edge, that the request, address and write data hold steady while the bus stalls, that nothing launches while busy, that the sticky flags never clear themselves, and that an engine blocked by a flag never raises a request. What only the directed scenarios can show is the arithmetic and the data path: the increment per size, the zero-extension of narrow reads, the exact address and data each access carries, and that a dropped collision leaves the address register untouched.

// File: rtl/sba_pkg.sv
package sba_pkg;

  localparam logic [6:0] OFF_CTRL    = 7'h38;
  localparam logic [6:0] OFF_ADDR_LO = 7'h39;
  localparam logic [6:0] OFF_ADDR_HI = 7'h3a;
  localparam logic [6:0] OFF_DATA_LO = 7'h3c;
  localparam logic [6:0] OFF_DATA_HI = 7'h3d;

  localparam int B_RD_DATA = 15;
  localparam int B_AUTOINC = 16;
  localparam int B_SIZE_LO = 17;
  localparam int B_RD_ADDR = 20;
  localparam int B_BUSY    = 21;
  localparam int B_BUSYERR = 22;
  localparam int B_ERR_LO  = 12;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_SIZE = 3'd4;
  localparam logic [2:0] CODE_BUS  = 3'd7;
  localparam logic [2:0] MAX_SIZE  = 3'd2;

  typedef struct packed {
    logic       rd_on_data;
    logic       auto_inc;
    logic [2:0] size;
    logic       rd_on_addr;
  } sba_cfg_t;

endpackage

// File: rtl/sba_csr.sv
module sba_csr
  import sba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  sba_cfg_t   cfg_wr,
  input  logic       clr_busyerr,
  input  logic [2:0] clr_err,
  input  logic       set_busyerr,
  input  logic       set_err,
  input  logic [2:0] set_code,
  output sba_cfg_t   cfg,
  output logic       busyerr,
  output logic [2:0] err
);

  sba_cfg_t   cfg_q, cfg_d;
  logic       busyerr_q, busyerr_d;
  logic [2:0] err_q, err_d;
  logic       flag_en;

  always_comb begin
    cfg_d     = cfg_q;
    busyerr_d = busyerr_q;
    err_d     = err_q;
    if (cfg_we) begin
      cfg_d     = cfg_wr;
      err_d     = err_q & ~clr_err;
      if (clr_busyerr) busyerr_d = 1'b0;
    end
    if (set_busyerr) busyerr_d = 1'b1;
    if (set_err)     err_d     = set_code;
  end

  assign flag_en = cfg_we | set_busyerr | set_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      busyerr_q <= 1'b0;
      err_q     <= CODE_NONE;
    end else begin
      if (cfg_we)  cfg_q <= cfg_d;
      if (flag_en) begin
        busyerr_q <= busyerr_d;
        err_q     <= err_d;
      end
    end
  end

  assign cfg     = cfg_q;
  assign busyerr = busyerr_q;
  assign err     = err_q;

  // R8: only an explicit write-1 may clear busy-error
  a_r8_busyerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busyerr_q && !(cfg_we && clr_busyerr) |=> busyerr_q);

  // R9: error code changes only through a write or a new error
  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we && !set_err |=> $stable(err_q));

endmodule

// File: rtl/sba_engine.sv
module sba_engine
  import sba_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_lo_we,
  input  logic          addr_hi_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic [2:0]    size_in,
  input  logic          inc_in,
  input  logic          mem_ready,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          done_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_size,
  output logic [DW-1:0] mem_wdata
);

  localparam int HI_W = AW - 32;

  typedef enum logic {ST_IDLE, ST_ACTIVE} st_e;

  st_e           st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          xwe_q, xwe_d, xinc_q, xinc_d;
  logic [2:0]    xsize_q, xsize_d;
  logic [DW-1:0] captured;
  logic [AW-1:0] step;
  logic          resp, launch;

  assign resp   = (st_q == ST_ACTIVE) && mem_ready;
  assign launch = start_rd || start_wr;
  assign step   = AW'(1) << xsize_q;

  always_comb begin
    case (xsize_q)
      3'd0:    captured = {{(DW-8){1'b0}},  mem_rdata[7:0]};
      3'd1:    captured = {{(DW-16){1'b0}}, mem_rdata[15:0]};
      default: captured = mem_rdata;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    data_d  = data_q;
    xwe_d   = xwe_q;
    xinc_d  = xinc_q;
    xsize_d = xsize_q;
    if (addr_lo_we) addr_d[31:0]    = wdata[31:0];
    if (addr_hi_we) addr_d[AW-1:32] = wdata[HI_W-1:0];
    if (data_we)    data_d          = wdata;
    if (launch) begin
      st_d    = ST_ACTIVE;
      xwe_d   = start_wr;
      xinc_d  = inc_in;
      xsize_d = size_in;
    end
    if (resp) begin
      st_d = ST_IDLE;
      if (!mem_err) begin
        if (!xwe_q) data_d = captured;
        if (xinc_q) addr_d = addr_q + step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      xwe_q   <= 1'b0;
      xinc_q  <= 1'b0;
      xsize_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      data_q <= data_d;
      if (launch) begin
        xwe_q   <= xwe_d;
        xinc_q  <= xinc_d;
        xsize_q <= xsize_d;
      end
    end
  end

  assign busy      = (st_q == ST_ACTIVE);
  assign addr      = addr_q;
  assign data      = data_q;
  assign done_err  = resp && mem_err;
  assign mem_req   = busy;
  assign mem_we    = xwe_q;
  assign mem_addr  = addr_q;
  assign mem_size  = xsize_q;
  assign mem_wdata = data_q;

  // R3: busy rises the cycle after a launch
  a_r3_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R3: busy falls on the response edge
  a_r3_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ready |=> !busy);

  // R3: request and its payload hold while the bus stalls
  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ready |=> busy && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

  // R7: a launch never overlaps an access in flight
  a_r7_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  // R6: read and write launch are exclusive
  a_r6_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_rd, start_wr}));

endmodule

// File: rtl/sba_ctrl.sv
module sba_ctrl
  import sba_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_req,
  input  logic              dbg_we,
  input  logic [6:0]        dbg_addr,
  input  logic [31:0]       dbg_wdata,
  output logic [31:0]       dbg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [2:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata
);

  localparam int DW   = 32;
  localparam int HI_W = ADDR_W - 32;

  logic rst_meta_q, rst_sync_q, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_ni = rst_sync_q;

  logic ev_ctrl_wr, ev_alo_wr, ev_ahi_wr, ev_dlo_wr, ev_dlo_rd;
  logic busy, busyerr, blocked, can_go, size_ok;
  logic want_rd, want_wr, start_rd, start_wr, collide, size_fault, done_err;
  logic [2:0]        err;
  sba_cfg_t          cfg, cfg_wr;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     data;
  logic [31:0]       ctrl_word;

  assign ev_ctrl_wr = dbg_req &&  dbg_we && (dbg_addr == OFF_CTRL);
  assign ev_alo_wr  = dbg_req &&  dbg_we && (dbg_addr == OFF_ADDR_LO);
  assign ev_ahi_wr  = dbg_req &&  dbg_we && (dbg_addr == OFF_ADDR_HI);
  assign ev_dlo_wr  = dbg_req &&  dbg_we && (dbg_addr == OFF_DATA_LO);
  assign ev_dlo_rd  = dbg_req && !dbg_we && (dbg_addr == OFF_DATA_LO);

  assign blocked    = busyerr || (err != CODE_NONE);
  assign can_go     = !busy && !blocked;
  assign size_ok    = (cfg.size <= MAX_SIZE);
  assign want_rd    = (ev_alo_wr && cfg.rd_on_addr) || (ev_dlo_rd && cfg.rd_on_data);
  assign want_wr    = ev_dlo_wr;
  assign start_rd   = can_go && size_ok && want_rd;
  assign start_wr   = can_go && size_ok && want_wr;
  assign size_fault = can_go && !size_ok && (want_rd || want_wr);
  assign collide    = busy && (ev_alo_wr || ev_ahi_wr || ev_dlo_wr || ev_dlo_rd);

  assign cfg_wr.rd_on_data = dbg_wdata[B_RD_DATA];
  assign cfg_wr.auto_inc   = dbg_wdata[B_AUTOINC];
  assign cfg_wr.size       = dbg_wdata[B_SIZE_LO+2:B_SIZE_LO];
  assign cfg_wr.rd_on_addr = dbg_wdata[B_RD_ADDR];

  sba_csr u_csr (
    .clk         (clk),
    .rst_n       (rst_ni),
    .cfg_we      (ev_ctrl_wr),
    .cfg_wr      (cfg_wr),
    .clr_busyerr (dbg_wdata[B_BUSYERR]),
    .clr_err     (dbg_wdata[B_ERR_LO+2:B_ERR_LO]),
    .set_busyerr (collide),
    .set_err     (size_fault || done_err),
    .set_code    (done_err ? CODE_BUS : CODE_SIZE),
    .cfg         (cfg),
    .busyerr     (busyerr),
    .err         (err)
  );

  sba_engine #(.AW(ADDR_W), .DW(DW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_ni),
    .addr_lo_we (ev_alo_wr && !busy),
    .addr_hi_we (ev_ahi_wr && !busy),
    .data_we    (ev_dlo_wr && !busy),
    .wdata      (dbg_wdata),
    .start_rd   (start_rd),
    .start_wr   (start_wr),
    .size_in    (cfg.size),
    .inc_in     (cfg.auto_inc),
    .mem_ready  (mem_ready),
    .mem_err    (mem_err),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .addr       (addr),
    .data       (data),
    .done_err   (done_err),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata)
  );

  always_comb begin
    ctrl_word                         = '0;
    ctrl_word[31:29]                  = 3'd1;
    ctrl_word[B_BUSYERR]              = busyerr;
    ctrl_word[B_BUSY]                 = busy;
    ctrl_word[B_RD_ADDR]              = cfg.rd_on_addr;
    ctrl_word[B_SIZE_LO+2:B_SIZE_LO]  = cfg.size;
    ctrl_word[B_AUTOINC]              = cfg.auto_inc;
    ctrl_word[B_RD_DATA]              = cfg.rd_on_data;
    ctrl_word[B_ERR_LO+2:B_ERR_LO]    = err;
    ctrl_word[11:5]                   = 7'(ADDR_W);
    ctrl_word[2:0]                    = 3'b111;
  end

  always_comb begin
    case (dbg_addr)
      OFF_CTRL:    dbg_rdata = ctrl_word;
      OFF_ADDR_LO: dbg_rdata = addr[31:0];
      OFF_ADDR_HI: dbg_rdata = 32'(addr[ADDR_W-1:ADDR_W-HI_W]);
      OFF_DATA_LO: dbg_rdata = data;
      default:     dbg_rdata = '0;
    endcase
  end

  // R7: a data read during an access raises busy-error
  a_r7_collide_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && ev_dlo_rd |=> busyerr);

  // R10: a pending flag keeps the bus quiet
  a_r10_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_req && blocked |=> !mem_req);

  // R11: an oversize attempt never reaches the bus
  a_r11_size_no_req: assert property (@(posedge clk) disable iff (!rst_ni)
    !size_ok && !busy |=> !mem_req);

endmodule

// File: tb/tb_sba_ctrl.sv
`timescale 1ns/1ps
module tb_sba_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_req, dbg_we;
  logic [6:0]  dbg_addr;
  logic [31:0] dbg_wdata, dbg_rdata;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [63:0] mem_addr;
  logic [2:0]  mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  sba_ctrl #(.ADDR_W(64)) dut (
    .clk(clk), .rst_n(rst_n),
    .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  int tests = 0;
  int fails = 0;

  // bus model state
  int          lat = 2;
  logic        inject = 1'b0;
  int          cnt = 0;
  int          n_acc = 0;
  logic [63:0] last_addr;
  logic        last_we;
  logic [31:0] last_wdata;
  logic [2:0]  last_size;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] cfgw(input logic rod, input logic ai,
                                       input logic [2:0] sz, input logic roa);
    return (32'(rod) << 15) | (32'(ai) << 16) | (32'(sz) << 17) | (32'(roa) << 20);
  endfunction

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      mem_err   = 1'b0;
      cnt       = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ready  = 1'b1;
        mem_err    = inject;
        mem_rdata  = pat(mem_addr[31:0]);
        last_addr  = mem_addr;
        last_we    = mem_we;
        last_wdata = mem_wdata;
        last_size  = mem_size;
        n_acc++;
      end else begin
        cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_req = 1'b1; dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_req = 1'b0; dbg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = a;
    #1 d = dbg_rdata;
    @(negedge clk);
    dbg_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (!mem_req) break;
    end
  endtask

  localparam logic [31:0] BASE = 32'h2000_0807;

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(7'h38, v); chk("R1 ctrl reset", v, BASE);
    reg_rd(7'h39, v); chk("R1 addr lo reset", v, 0);
    reg_rd(7'h3a, v); chk("R1 addr hi reset", v, 0);
    reg_rd(7'h3c, v); chk("R1 data lo reset", v, 0);
    reg_rd(7'h3d, v); chk("R1 data hi reset", v, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    int n0 = n_acc;
    reg_wr(7'h38, cfgw(1, 1, 3'd2, 1) | (32'd1 << 21));
    reg_rd(7'h38, v);
    chk("R2 fields readback, busy read-only", v, BASE | cfgw(1, 1, 3'd2, 1));
    repeat (4) @(negedge clk);
    chk("R2 ctrl write starts nothing", n_acc, n0);
    reg_wr(7'h38, 0);
  endtask

  task automatic t_rd_on_addr();
    logic [31:0] v;
    lat = 3;
    reg_wr(7'h38, cfgw(0, 1, 3'd2, 1));
    reg_wr(7'h39, 32'h4000_0000);
    chk("R3 mem_req after address write", mem_req, 1);
    chk("R3 bus address", mem_addr, 64'h4000_0000);
    reg_rd(7'h38, v);
    chk("R3 busy while in flight", v[21], 1);
    wait_idle();
    reg_rd(7'h38, v);
    chk("R3 busy clear after response", v[21], 0);
    reg_rd(7'h3c, v);
    chk("R3 captured data", v, pat(32'h4000_0000));
    reg_rd(7'h39, v);
    chk("R5 increment by 4", v, 32'h4000_0004);
    chk("R12 size on bus", last_size, 2);
  endtask

  task automatic t_rd_on_data();
    logic [31:0] v;
    int n0 = n_acc;
    reg_wr(7'h38, cfgw(1, 1, 3'd2, 0));
    reg_rd(7'h3c, v);
    chk("R4 returns held data", v, pat(32'h4000_0000));
    wait_idle();
    chk("R4 launched one read", n_acc, n0 + 1);
    chk("R4 read address", last_addr, 64'h4000_0004);
    reg_rd(7'h3c, v);
    chk("R4 streamed data", v, pat(32'h4000_0004));
    wait_idle();
    reg_wr(7'h38, 0);
    reg_rd(7'h39, v);
    chk("R5 address after stream", v, 32'h4000_000C);
  endtask

  task automatic t_no_inc();
    logic [31:0] v;
    reg_wr(7'h38, cfgw(0, 0, 3'd2, 1));
    reg_wr(7'h39, 32'h100);
    wait_idle();
    reg_rd(7'h39, v);
    chk("R5 no increment when disabled", v, 32'h100);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int n0 = n_acc;
    reg_wr(7'h38, cfgw(0, 1, 3'd2, 0));
    reg_wr(7'h39, 32'h200);
    repeat (4) @(negedge clk);
    chk("R6 address write alone starts nothing", n_acc, n0);
    reg_wr(7'h3c, 32'hCAFE_F00D);
    wait_idle();
    chk("R6 bus write issued", n_acc, n0 + 1);
    chk("R6 write flag", last_we, 1);
    chk("R6 write address", last_addr, 64'h200);
    chk("R6 write data", last_wdata, 32'hCAFE_F00D);
    reg_rd(7'h39, v);
    chk("R6 increment after write", v, 32'h204);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int n0 = n_acc;
    lat = 6;
    reg_wr(7'h38, cfgw(0, 1, 3'd2, 1));
    reg_wr(7'h39, 32'h300);
    reg_rd(7'h3c, v);
    chk("R7 busy read returns current data", v, 32'hCAFE_F00D);
    reg_wr(7'h39, 32'h999);
    wait_idle();
    chk("R7 only one access", n_acc, n0 + 1);
    reg_rd(7'h39, v);
    chk("R7 dropped address write", v, 32'h304);
    reg_rd(7'h38, v);
    chk("R7 busy-error set", v[22], 1);
    lat = 2;
  endtask

  task automatic t_sticky_block();
    logic [31:0] v;
    int n0 = n_acc;
    reg_wr(7'h38, cfgw(1, 1, 3'd2, 1));
    reg_rd(7'h38, v);
    chk("R8 writing 0 keeps busy-error", v[22], 1);
    reg_wr(7'h39, 32'h500);
    reg_rd(7'h3c, v);
    reg_wr(7'h3c, 32'h1234_5678);
    repeat (4) @(negedge clk);
    chk("R10 no access while busy-error", n_acc, n0);
    reg_rd(7'h39, v);
    chk("R10 address still written", v, 32'h500);
    reg_rd(7'h3c, v);
    chk("R10 data still written", v, 32'h1234_5678);
    reg_wr(7'h38, cfgw(0, 1, 3'd2, 1) | (32'd1 << 22));
    reg_rd(7'h38, v);
    chk("R8 write-1 clears busy-error", v[22], 0);
  endtask

  task automatic t_bus_err();
    logic [31:0] v;
    int n0;
    inject = 1'b1;
    reg_wr(7'h39, 32'h600);
    wait_idle();
    inject = 1'b0;
    reg_rd(7'h38, v);
    chk("R9 bus error code", v[14:12], 7);
    reg_rd(7'h39, v);
    chk("R9 no increment on error", v, 32'h600);
    reg_rd(7'h3c, v);
    chk("R9 data unchanged on error", v, 32'h1234_5678);
    n0 = n_acc;
    reg_wr(7'h39, 32'h700);
    repeat (4) @(negedge clk);
    chk("R10 no access with error code", n_acc, n0);
    reg_wr(7'h38, cfgw(0, 1, 3'd2, 1) | (32'd3 << 12));
    reg_rd(7'h38, v);
    chk("R9 per-bit clear", v[14:12], 4);
    reg_wr(7'h38, cfgw(0, 1, 3'd2, 1) | (32'd4 << 12));
    reg_rd(7'h38, v);
    chk("R9 fully cleared", v[14:12], 0);
  endtask

  task automatic t_bad_size();
    logic [31:0] v;
    int n0 = n_acc;
    reg_wr(7'h38, cfgw(0, 1, 3'd3, 1));
    reg_wr(7'h39, 32'h800);
    repeat (4) @(negedge clk);
    chk("R11 no access for size 3", n_acc, n0);
    reg_rd(7'h38, v);
    chk("R11 size error code", v[14:12], 4);
    reg_wr(7'h38, 32'd7 << 12);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    reg_wr(7'h38, cfgw(0, 1, 3'd0, 1));
    reg_wr(7'h39, 32'h4000_0003);
    wait_idle();
    reg_rd(7'h3c, v);
    chk("R12 byte read zero-extended", v, {24'h0, pat(32'h4000_0003)[7:0]});
    chk("R12 byte size on bus", last_size, 0);
    reg_rd(7'h39, v);
    chk("R5 increment by 1", v, 32'h4000_0004);
    reg_wr(7'h38, cfgw(0, 1, 3'd1, 1));
    reg_wr(7'h39, 32'h4000_0010);
    wait_idle();
    reg_rd(7'h3c, v);
    chk("R12 halfword read zero-extended", v, {16'h0, pat(32'h4000_0010)[15:0]});
    reg_rd(7'h39, v);
    chk("R5 increment by 2", v, 32'h4000_0012);
  endtask

  task automatic t_high();
    logic [31:0] v;
    reg_wr(7'h3a, 32'h0000_0001);
    reg_rd(7'h3a, v);
    chk("R13 high address readback", v, 1);
    reg_wr(7'h38, cfgw(0, 0, 3'd2, 1));
    reg_wr(7'h39, 32'h20);
    wait_idle();
    chk("R13 high address on bus", last_addr, 64'h1_0000_0020);
    reg_wr(7'h3d, 32'hFFFF_FFFF);
    reg_rd(7'h3d, v);
    chk("R13 data hi reads zero", v, 0);
    reg_rd(7'h3c, v);
    chk("R13 data hi write has no effect", v, pat(32'h20));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; dbg_req = 1'b0; dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    mem_ready = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_rd_on_addr();
    t_rd_on_data();
    t_no_inc();
    t_write();
    t_collide();
    t_sticky_block();
    t_bus_err();
    t_bad_size();
    t_narrow();
    t_high();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule